// File: doc/BRIEF.md
# Character-Typed Vector Execution Lane

This block is one execution lane dedicated to a single data type, here 8-bit characters. It holds a 32-entry register file of character values and an arithmetic-logic stage with four parallel lane slices. A request names an operation, a destination register, two source registers, a vector-mode flag and a lane count. In scalar mode exactly one element is processed. In vector mode, 1 to 16 consecutive elements are processed, four per clock.

Each result either returns to the register file or leaves on a store port toward a shared data path. The character unit offers only addition, subtraction, bitwise logic and comparison. Multiplication and division encodings are refused. A line-enable input gates the whole lane. While it is low, nothing is accepted and nothing is written.

Top module: `char_vec_lane`

## Requirements
- R1: After reset, `busy`, `done` and `st_valid` are low and every register reads back 0.
- R2: A load (`ld_en` high while `line_en` is high) writes `ld_data` into register `ld_idx` at the clock edge. `rd_data` shows register `rd_idx` combinationally.
- R3: Operation code 0 is add and code 1 is subtract (a minus b). Both wrap modulo 256, and no overflow indication exists.
- R4: Code 2 is AND, code 3 is OR and code 4 is XOR of a and b. Code 5 is the bitwise inverse of a.
- R5: Code 6 (equal) and code 7 (unsigned a less than b) write 8'h01 when true and 8'h00 when false.
- R6: With `vec_mode` low, exactly one element is processed whatever `lane_cnt` holds, and `done` rises one cycle after acceptance.
- R7: With `vec_mode` high, element k reads registers a+k and b+k and targets register dst+k, all modulo 32. A lane count of 0 acts as 1, and a count above 16 acts as 16.
- R8: Four elements complete per clock. For n elements, `busy` lasts ceil(n/4) cycles and `done` is a one-cycle pulse in the cycle after the last group. A later group reads values that earlier groups of the same operation have already written.
- R9: With `to_store` high, no register changes. Each group appears for one cycle on the store port: `st_valid` high, `st_mask` bit j set for each live element j, `st_idx` = dst + 4*group, and element j in `st_data[8j+7:8j]`.
- R10: While `line_en` is low, requests and loads are ignored. An operation in flight is dropped with no further writes and no `done`, and `busy` stays low.
- R11: Codes 8 to 15, which include the multiply and divide encodings, are refused: `busy` stays low and no register changes.
- R12: When a load and an element result target the same register in the same cycle, the element result is kept. When they target different registers, both take effect.
- R13: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_en | input | 1 | Lane enable |
| start | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| vec_mode | input | 1 | 1 = vector, 0 = scalar |
| lane_cnt | input | 5 | Requested element count |
| dst_idx | input | 5 | Destination base register |
| src_a_idx | input | 5 | First source base register |
| src_b_idx | input | 5 | Second source base register |
| to_store | input | 1 | 1 = send results to store port |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 5 | Register load index |
| ld_data | input | 8 | Register load value |
| rd_idx | input | 5 | Readback index |
| rd_data | output | 8 | Readback value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| st_valid | output | 1 | Store beat valid |
| st_mask | output | 4 | Live elements of the beat |
| st_idx | output | 5 | Destination index of element 0 of the beat |
| st_data | output | 32 | Four element results |

## Verification
A register load and an element writeback can land in the same clock edge. The bench provokes this by raising `ld_en` in the cycle between acceptance and the first group write. In one case the load targets the operation's destination register, and the element result must be the value kept. In the other case the load targets an unrelated register, and both writes must appear.

The other overlap is between groups of one vector operation. Here the destination range is placed four registers above a source range, so later groups must read earlier results. The bench model applies groups in sequence and checks the register file against that model.

// File: rtl/char_vec_lane.sv
module char_vec_lane #(
  parameter int DW   = 8,
  parameter int NREG = 32,
  parameter int MAXL = 16,
  parameter int GRP  = 4,
  parameter int OPW  = 4,
  parameter int CNTW = 5,
  parameter int IW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_en,
  input  logic              start,
  input  logic [OPW-1:0]    op,
  input  logic              vec_mode,
  input  logic [CNTW-1:0]   lane_cnt,
  input  logic [IW-1:0]     dst_idx,
  input  logic [IW-1:0]     src_a_idx,
  input  logic [IW-1:0]     src_b_idx,
  input  logic              to_store,
  input  logic              ld_en,
  input  logic [IW-1:0]     ld_idx,
  input  logic [DW-1:0]     ld_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [DW-1:0]     rd_data,
  output logic              busy,
  output logic              done,
  output logic              st_valid,
  output logic [GRP-1:0]    st_mask,
  output logic [IW-1:0]     st_idx,
  output logic [GRP*DW-1:0] st_data
);
  localparam int LW  = $clog2(MAXL + 1);
  localparam int GCW = $clog2((MAXL + GRP - 1) / GRP + 1);
  localparam int NOPS = 8;

  localparam logic [OPW-1:0] OP_ADD = OPW'(0);
  localparam logic [OPW-1:0] OP_SUB = OPW'(1);
  localparam logic [OPW-1:0] OP_AND = OPW'(2);
  localparam logic [OPW-1:0] OP_OR  = OPW'(3);
  localparam logic [OPW-1:0] OP_XOR = OPW'(4);
  localparam logic [OPW-1:0] OP_NOT = OPW'(5);
  localparam logic [OPW-1:0] OP_EQ  = OPW'(6);
  localparam logic [OPW-1:0] OP_LTU = OPW'(7);

  logic [DW-1:0]  rf [NREG];
  logic [OPW-1:0] q_op;
  logic [IW-1:0]  q_d, q_a, q_b;
  logic [LW-1:0]  q_n;
  logic           q_st;
  logic [GCW-1:0] q_lastg, grp;

  logic [LW-1:0]  n_eff;
  logic           op_ok, accept, last_grp;
  logic [GRP-1:0] lane_ok;
  logic [IW-1:0]  dst_ix [GRP];
  logic [DW-1:0]  lres   [GRP];

  assign rd_data  = rf[rd_idx];
  assign op_ok    = int'(op) < NOPS;
  assign accept   = line_en && start && !busy && op_ok;
  assign last_grp = grp == q_lastg;

  always_comb begin
    if (!vec_mode || lane_cnt == '0) n_eff = LW'(1);
    else if (int'(lane_cnt) > MAXL)  n_eff = LW'(MAXL);
    else                             n_eff = LW'(lane_cnt);
  end

  for (genvar j = 0; j < GRP; j++) begin : g_lane
    logic [IW-1:0] off, ia, ib;
    logic [DW-1:0] a, b;
    assign off        = IW'(int'(grp) * GRP + j);
    assign ia         = q_a + off;
    assign ib         = q_b + off;
    assign dst_ix[j]  = q_d + off;
    assign a          = rf[ia];
    assign b          = rf[ib];
    assign lane_ok[j] = (int'(grp) * GRP + j) < int'(q_n);
    always_comb begin
      case (q_op)
        OP_ADD:  lres[j] = a + b;
        OP_SUB:  lres[j] = a - b;
        OP_AND:  lres[j] = a & b;
        OP_OR:   lres[j] = a | b;
        OP_XOR:  lres[j] = a ^ b;
        OP_NOT:  lres[j] = ~a;
        OP_EQ:   lres[j] = DW'(a == b);
        OP_LTU:  lres[j] = DW'(a < b);
        default: lres[j] = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      st_valid <= 1'b0;
      st_mask  <= '0;
      st_idx   <= '0;
      st_data  <= '0;
      q_op     <= '0;
      q_d      <= '0;
      q_a      <= '0;
      q_b      <= '0;
      q_n      <= '0;
      q_st     <= 1'b0;
      q_lastg  <= '0;
      grp      <= '0;
    end else begin
      done     <= 1'b0;
      st_valid <= 1'b0;
      if (!line_en) begin
        busy <= 1'b0;
      end else begin
        if (ld_en) rf[ld_idx] <= ld_data;
        if (busy) begin
          for (int j = 0; j < GRP; j++) begin
            if (lane_ok[j] && !q_st) rf[dst_ix[j]] <= lres[j];
            st_data[j*DW +: DW] <= lres[j];
          end
          st_valid <= q_st;
          st_mask  <= lane_ok;
          st_idx   <= dst_ix[0];
          if (last_grp) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            grp <= grp + 1'b1;
          end
        end else if (accept) begin
          busy    <= 1'b1;
          grp     <= '0;
          q_op    <= op;
          q_d     <= dst_idx;
          q_a     <= src_a_idx;
          q_b     <= src_b_idx;
          q_st    <= to_store;
          q_n     <= n_eff;
          q_lastg <= GCW'((int'(n_eff) - 1) / GRP);
        end
      end
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !done && !st_valid);
  a_r8_done_pulse:       assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_done_not_busy:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r6_scalar_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                                          (busy && line_en && q_n == LW'(1)) |=> done);
  a_r9_store_mask:       assert property (@(posedge clk) disable iff (!rst_n) st_valid |-> st_mask[0]);
  a_r10_off_idle:        assert property (@(posedge clk) disable iff (!rst_n)
                                          !line_en |=> !busy && !done && !st_valid);
  a_r11_reject:          assert property (@(posedge clk) disable iff (!rst_n)
                                          (line_en && start && !busy && !op_ok) |=> !busy);
  a_r13_keep_busy:       assert property (@(posedge clk) disable iff (!rst_n)
                                          (busy && line_en && !last_grp) |=> busy && $stable(q_op));
endmodule

// File: tb/char_vec_lane_tb_top.sv
module char_vec_lane_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  mask;
    logic [4:0]  idx;
    logic [31:0] data;
  } beat_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        line_en = 1'b1, start = 1'b0, vec_mode = 1'b0, to_store = 1'b0, ld_en = 1'b0;
  logic [3:0]  op = '0;
  logic [4:0]  lane_cnt = '0, dst_idx = '0, src_a_idx = '0, src_b_idx = '0, ld_idx = '0, rd_idx = '0;
  logic [7:0]  ld_data = '0, rd_data;
  logic        busy, done, st_valid;
  logic [3:0]  st_mask;
  logic [4:0]  st_idx;
  logic [31:0] st_data;

  logic [7:0] m [32];
  beat_t      exp_q [$];
  int         checks = 0, errors = 0;
  bit         finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  char_vec_lane dut_i (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .start(start), .op(op),
    .vec_mode(vec_mode), .lane_cnt(lane_cnt), .dst_idx(dst_idx),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .to_store(to_store),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .busy(busy), .done(done), .st_valid(st_valid),
    .st_mask(st_mask), .st_idx(st_idx), .st_data(st_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] alu(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
    case (o)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd5: return ~a;
      4'd6: return (a == b) ? 8'h01 : 8'h00;
      4'd7: return (a < b) ? 8'h01 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_op(input logic [3:0] o, input int d, input int a, input int b,
                          input bit vec, input int cnt, input bit st);
    int n;
    n = (!vec || cnt == 0) ? 1 : (cnt > 16 ? 16 : cnt);
    for (int g = 0; g * 4 < n; g++) begin
      logic [7:0] r [4];
      beat_t bt;
      bt.mask = '0;
      for (int j = 0; j < 4; j++) begin
        r[j] = alu(o, m[(a + g*4 + j) % 32], m[(b + g*4 + j) % 32]);
        if (g*4 + j < n) bt.mask[j] = 1'b1;
      end
      if (st) begin
        bt.idx  = 5'((d + g*4) % 32);
        bt.data = {r[3], r[2], r[1], r[0]};
        exp_q.push_back(bt);
      end else begin
        for (int j = 0; j < 4; j++) if (bt.mask[j]) m[(d + g*4 + j) % 32] = r[j];
      end
    end
  endtask

  task automatic load(input int idx, input logic [7:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 5'(idx); ld_data = v;
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0;
    if (line_en) m[idx] = v;
  endtask

  task automatic issue(input logic [3:0] o, input int d, input int a, input int b,
                       input bit vec, input int cnt, input bit st);
    @(negedge clk);
    op = o; dst_idx = 5'(d); src_a_idx = 5'(a); src_b_idx = 5'(b);
    vec_mode = vec; lane_cnt = 5'(cnt); to_store = st; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int exp_cyc, input string req);
    int c = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      c++;
    end while (!done && c < 40);
    check(done && c == exp_cyc, req, "cycles to done", c, exp_cyc);
    @(posedge clk);
    @(negedge clk);
    check(!done && !busy, req, "done is one-cycle pulse", {done, busy}, 0);
  endtask

  task automatic run(input logic [3:0] o, input int d, input int a, input int b,
                     input bit vec, input int cnt, input bit st, input int cyc, input string req);
    issue(o, d, a, b, vec, cnt, st);
    model_op(o, d, a, b, vec, cnt, st);
    wait_done(cyc, req);
  endtask

  task automatic check_regs(input string req);
    int bad = 0, first = -1;
    logic [7:0] act = '0, exp = '0;
    for (int i = 0; i < 32; i++) begin
      rd_idx = 5'(i);
      #1;
      if (rd_data !== m[i]) begin
        if (first < 0) begin first = i; act = rd_data; exp = m[i]; end
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("register file (first bad r%0d)", first), act, exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && st_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected store beat", {st_mask, st_idx}, 0);
      end else begin
        beat_t e;
        bit ok;
        e = exp_q.pop_front();
        ok = (st_mask == e.mask) && (st_idx == e.idx);
        for (int j = 0; j < 4; j++)
          if (e.mask[j] && st_data[j*8 +: 8] !== e.data[j*8 +: 8]) ok = 0;
        check(ok, "R9", "store beat", st_data, e.data);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      check(0, "watchdog", "run did not complete", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !st_valid, "R1", "idle outputs after reset", {busy, done, st_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1");

    // R2: load and read back
    for (int i = 0; i < 32; i++) load(i, 8'(i * 29 + 7));
    check_regs("R2");

    // R3: wrapping add and subtract
    load(1, 8'd200); load(2, 8'd100); load(3, 8'd5); load(4, 8'd10);
    run(4'd0, 10, 1, 2, 0, 0, 0, 1, "R3");
    check_regs("R3 add wrap");
    run(4'd1, 11, 3, 4, 0, 0, 0, 1, "R3");
    check_regs("R3 sub wrap");

    // R4: logic
    run(4'd2, 12, 1, 2, 0, 0, 0, 1, "R4");
    run(4'd3, 13, 1, 2, 0, 0, 0, 1, "R4");
    run(4'd4, 14, 1, 2, 0, 0, 0, 1, "R4");
    run(4'd5, 15, 1, 2, 0, 0, 0, 1, "R4");
    check_regs("R4 logic ops");

    // R5: compares, true and false
    load(5, 8'd100);
    run(4'd6, 16, 2, 5, 0, 0, 0, 1, "R5");
    run(4'd6, 17, 1, 2, 0, 0, 0, 1, "R5");
    run(4'd7, 18, 2, 1, 0, 0, 0, 1, "R5");
    run(4'd7, 19, 1, 2, 0, 0, 0, 1, "R5");
    check_regs("R5 compares");

    // R6: scalar ignores lane count
    run(4'd0, 20, 6, 7, 0, 9, 0, 1, "R6");
    check_regs("R6 scalar");

    // R7/R8: vector with register wrap, 10 elements, 3 groups
    run(4'd4, 28, 0, 16, 1, 10, 0, 3, "R7 R8");
    check_regs("R7 wrap");
    run(4'd0, 8, 20, 21, 1, 0, 0, 1, "R7 count zero");
    check_regs("R7 count zero");
    run(4'd1, 0, 8, 24, 1, 31, 0, 4, "R7 clamp");
    check_regs("R7 clamp");

    // R8: later groups see earlier results
    run(4'd0, 4, 0, 16, 1, 8, 0, 2, "R8");
    check_regs("R8 chained groups");

    // R9: store port, registers untouched
    run(4'd3, 2, 10, 20, 1, 6, 1, 2, "R9");
    check_regs("R9 no register change");
    check(exp_q.size() == 0, "R9", "all store beats seen", exp_q.size(), 0);

    // R10: requests and loads ignored while disabled, in-flight dropped
    @(negedge clk); line_en = 1'b0;
    issue(4'd0, 0, 1, 2, 0, 0, 0);
    check(!busy, "R10", "request ignored while disabled", busy, 0);
    load(0, 8'hAA);
    check_regs("R10 load ignored");
    line_en = 1'b1;
    issue(4'd0, 0, 16, 16, 1, 16, 0);
    model_op(4'd0, 0, 16, 16, 1, 4, 0);
    @(posedge clk);
    @(negedge clk);
    line_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!busy && !done, "R10", "in-flight dropped", {busy, done}, 0);
    repeat (4) @(negedge clk);
    check(!done && !busy, "R10", "no late done", {busy, done}, 0);
    line_en = 1'b1;
    check_regs("R10 only first group written");

    // R11: refused codes
    issue(4'd9, 0, 1, 2, 0, 0, 0);
    check(!busy, "R11", "code 9 refused", busy, 0);
    repeat (3) @(negedge clk);
    check(!done, "R11", "no done for refused code", done, 0);
    issue(4'd15, 0, 1, 2, 1, 4, 0);
    check(!busy, "R11", "code 15 refused", busy, 0);
    check_regs("R11 no change");

    // R12: load collides with element write
    issue(4'd0, 3, 1, 2, 0, 0, 0);
    ld_en = 1'b1; ld_idx = 5'd3; ld_data = 8'h77;
    model_op(4'd0, 3, 1, 2, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0;
    check(done, "R12", "scalar done", done, 1);
    check_regs("R12 element wins");
    issue(4'd2, 20, 1, 2, 1, 4, 0);
    ld_en = 1'b1; ld_idx = 5'd9; ld_data = 8'h5C;
    model_op(4'd2, 20, 1, 2, 1, 4, 0);
    m[9] = 8'h5C;
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0;
    check(done, "R12", "vector done", done, 1);
    check_regs("R12 both writes");

    // R13: second request while busy ignored
    issue(4'd0, 12, 0, 16, 1, 16, 0);
    model_op(4'd0, 12, 0, 16, 1, 16, 0);
    op = 4'd4; dst_idx = 5'd0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(3, "R13");
    check_regs("R13 only first request");
    check(exp_q.size() == 0, "R9", "store queue empty at end", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule